// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block holds the 16-bit status and configuration word of a serial NOR flash and enforces who may change it. Upstream instruction decoding delivers one-cycle strobes for write enable, write disable, status write, program, erase, suspend, resume and quad-instruction mode entry. The block answers each strobe in the same cycle with an accept flag and updates its state on the following clock edge. The current word is always visible for status reads.

An abstract operation timer ends a busy period by pulsing a done input. A soft power-cycle input models a supply drop. It clears the volatile state and keeps the bits that are treated as non-volatile. The asynchronous reset returns everything, non-volatile bits included, to the factory state.

Top module: `flash_status_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, `status_o` reads 0x0000 and `qpi_mode_o` is 0.
- R2: Write enable sets WEL (bit 1) and write disable clears it. Both are accepted whenever BUSY (bit 0) is 0.
- R3: Program and erase are accepted only when WEL=1 and BUSY=0. An accepted program or erase sets BUSY and clears WEL. BUSY returns to 0 on the edge where `op_done_i` is high.
- R4: While BUSY=1, every strobe except suspend is rejected and changes no bit.
- R5: With protect mode SRP1:SRP0 = 00 (bits 8:7), a status write needs only WEL=1, and `wp_ni` has no effect. An accepted write loads CMP (bit 14), QE (bit 9), SRP1 (bit 8), SRP0 (bit 7), SEC (bit 6), TB (bit 5) and BP2..BP0 (bits 4:2) from `wr_data_i`. It also sets BUSY and clears WEL.
- R6: With protect mode 01, while QE=0 and the block is not in quad mode, a status write is rejected when `wp_ni` is 0 and allowed when it is 1. When QE=1 the pin is ignored.
- R7: A rejected status write, when BUSY=0, leaves every other bit unchanged, clears WEL, does not set BUSY and drops the accept flag.
- R8: Protect mode 10 rejects all status writes until a power cycle, and the power cycle returns the mode to 00. Mode 11 rejects all status writes permanently, across power cycles.
- R9: The lock bits LB3..LB1 (bits 13:11) are OR-ed with the written data. Once set, a lock bit is never cleared by a status write or a power cycle.
- R10: Suspend is accepted only while a program or erase is busy and SUS=0. It sets SUS (bit 15) and clears BUSY. Resume is accepted when SUS=1 and BUSY=0. It clears SUS and sets BUSY again.
- R11: Quad mode entry is rejected unless QE=1. While in quad mode, QE stays 1, and a status write with data bit 9 = 0 keeps it at 1.
- R12: A power cycle clears BUSY, WEL, SUS and quad mode, and it keeps CMP, LB, QE, SEC, TB and BP. Accept is 0 in that cycle.
- R13: Bit 10 always reads 0. The data bits for SUS, WEL, BUSY and the reserved bit are ignored by a status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low factory reset |
| pwr_cycle_i | input | 1 | Soft power-cycle pulse |
| wren_i | input | 1 | Write enable strobe |
| wrdi_i | input | 1 | Write disable strobe |
| wrsr_i | input | 1 | Status write strobe |
| wr_data_i | input | 16 | Status write data |
| prog_i | input | 1 | Program strobe (array or security area) |
| erase_i | input | 1 | Erase strobe (array or security area) |
| suspend_i | input | 1 | Suspend strobe |
| resume_i | input | 1 | Resume strobe |
| enter_qpi_i | input | 1 | Quad instruction mode entry strobe |
| wp_ni | input | 1 | Write-protect pin, active low |
| op_done_i | input | 1 | End-of-operation pulse from the timer |
| status_o | output | 16 | Status and configuration word |
| qpi_mode_o | output | 1 | Quad instruction mode active |
| cmd_accept_o | output | 1 | The strobe present this cycle is accepted |

## Verification
The embedded properties check these rules on every cycle: the lock bits never fall, mode 11 persists and mode 10 persists without a power cycle, and non-volatile bits hold still while BUSY is set. They also check that BUSY persists until a done, suspend or power cycle, that SUS persists until resume or a power cycle, and that quad mode implies QE=1. A status write blocked by the pin leaves BUSY low. The exact data merge, the interaction of the pin with QE, release of the lock-down by a power cycle, and the suspend/resume round trip are only shown by the bench's instruction sequences, which compare the full word after each step.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int unsigned SR_W = 16;
  localparam int unsigned LB_W = 3;
  localparam int unsigned BP_W = 3;

  localparam int unsigned B_BUSY = 0;
  localparam int unsigned B_WEL  = 1;
  localparam int unsigned B_BP   = 2;
  localparam int unsigned B_TB   = B_BP + BP_W;
  localparam int unsigned B_SEC  = B_TB + 1;
  localparam int unsigned B_SRP0 = B_SEC + 1;
  localparam int unsigned B_SRP1 = B_SRP0 + 1;
  localparam int unsigned B_QE   = B_SRP1 + 1;
  localparam int unsigned B_RSV  = B_QE + 1;
  localparam int unsigned B_LB   = B_RSV + 1;
  localparam int unsigned B_CMP  = B_LB + LB_W;
  localparam int unsigned B_SUS  = B_CMP + 1;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_WREN, CMD_WRDI, CMD_WRSR, CMD_PROG,
    CMD_ERASE, CMD_SUSPEND, CMD_RESUME, CMD_ENTER_QPI
  } fsr_cmd_e;

  typedef enum logic [1:0] {
    PM_SOFT = 2'b00, PM_PIN = 2'b01, PM_LOCKDOWN = 2'b10, PM_OTP = 2'b11
  } fsr_pmode_e;

  typedef struct packed {
    logic            cmp;
    logic [LB_W-1:0] lb;
    logic            qe;
    logic [1:0]      srp;
    logic            sec;
    logic            tb;
    logic [BP_W-1:0] bp;
  } fsr_nv_t;

  function automatic fsr_nv_t merge_nv(fsr_nv_t cur, logic [SR_W-1:0] d, logic keep_qe);
    fsr_nv_t n;
    n.cmp = d[B_CMP];
    n.lb  = cur.lb | d[B_LB +: LB_W];
    n.qe  = d[B_QE] | (keep_qe & cur.qe);
    n.srp = {d[B_SRP1], d[B_SRP0]};
    n.sec = d[B_SEC];
    n.tb  = d[B_TB];
    n.bp  = d[B_BP +: BP_W];
    return n;
  endfunction

  function automatic logic [SR_W-1:0] pack_sr(fsr_nv_t nv, logic sus, logic wel, logic busy);
    logic [SR_W-1:0] s;
    s = '0;
    s[B_SUS]          = sus;
    s[B_CMP]          = nv.cmp;
    s[B_LB +: LB_W]   = nv.lb;
    s[B_QE]           = nv.qe;
    s[B_SRP1]         = nv.srp[1];
    s[B_SRP0]         = nv.srp[0];
    s[B_SEC]          = nv.sec;
    s[B_TB]           = nv.tb;
    s[B_BP +: BP_W]   = nv.bp;
    s[B_WEL]          = wel;
    s[B_BUSY]         = busy;
    return s;
  endfunction
endpackage

// File: rtl/fsr_cmd_sel.sv
module fsr_cmd_sel
  import fsr_pkg::*;
(
  input  logic     wren_i,
  input  logic     wrdi_i,
  input  logic     wrsr_i,
  input  logic     prog_i,
  input  logic     erase_i,
  input  logic     suspend_i,
  input  logic     resume_i,
  input  logic     enter_qpi_i,
  output fsr_cmd_e cmd_o
);
  // fixed priority when strobes collide: suspend first
  always_comb begin
    if (suspend_i)        cmd_o = CMD_SUSPEND;
    else if (resume_i)    cmd_o = CMD_RESUME;
    else if (wrsr_i)      cmd_o = CMD_WRSR;
    else if (prog_i)      cmd_o = CMD_PROG;
    else if (erase_i)     cmd_o = CMD_ERASE;
    else if (wrdi_i)      cmd_o = CMD_WRDI;
    else if (wren_i)      cmd_o = CMD_WREN;
    else if (enter_qpi_i) cmd_o = CMD_ENTER_QPI;
    else                  cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/fsr_access.sv
module fsr_access
  import fsr_pkg::*;
(
  input  logic [1:0] srp_i,
  input  logic       qe_i,
  input  logic       qpi_i,
  input  logic       wp_ni,
  output logic       permit_o
);
  fsr_pmode_e mode;
  logic       pin_live;

  assign mode     = fsr_pmode_e'(srp_i);
  // pin is a data line once quad I/O is enabled
  assign pin_live = !qe_i && !qpi_i;

  always_comb begin
    unique case (mode)
      PM_SOFT:     permit_o = 1'b1;
      PM_PIN:      permit_o = !pin_live || wp_ni;
      PM_LOCKDOWN: permit_o = 1'b0;
      default:     permit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fsr_state.sv
module fsr_state
  import fsr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_cycle_i,
  input  logic            op_done_i,
  input  fsr_cmd_e        cmd_i,
  input  logic [SR_W-1:0] wr_data_i,
  input  logic            wr_permit_i,
  input  logic            wp_ni,
  output logic            accept_o,
  output fsr_nv_t         nv_o,
  output logic            wel_o,
  output logic            busy_o,
  output logic            sus_o,
  output logic            qpi_o
);
  fsr_nv_t nv_q;
  logic    wel_q, busy_q, busy_pe_q, sus_q, qpi_q;
  logic    acc;

  always_comb begin
    unique case (cmd_i)
      CMD_WREN, CMD_WRDI:  acc = !busy_q;
      CMD_WRSR:            acc = !busy_q && wel_q && wr_permit_i;
      CMD_PROG, CMD_ERASE: acc = !busy_q && wel_q;
      CMD_SUSPEND:         acc = busy_q && busy_pe_q && !sus_q;
      CMD_RESUME:          acc = !busy_q && sus_q;
      CMD_ENTER_QPI:       acc = !busy_q && nv_q.qe;
      default:             acc = 1'b0;
    endcase
    if (pwr_cycle_i) acc = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q      <= '0;
      wel_q     <= 1'b0;
      busy_q    <= 1'b0;
      busy_pe_q <= 1'b0;
      sus_q     <= 1'b0;
      qpi_q     <= 1'b0;
    end else if (pwr_cycle_i) begin
      wel_q     <= 1'b0;
      busy_q    <= 1'b0;
      busy_pe_q <= 1'b0;
      sus_q     <= 1'b0;
      qpi_q     <= 1'b0;
      if (nv_q.srp == PM_LOCKDOWN) nv_q.srp <= PM_SOFT;
    end else begin
      if (op_done_i && busy_q) begin
        busy_q    <= 1'b0;
        busy_pe_q <= 1'b0;
      end
      unique case (cmd_i)
        CMD_WREN: if (acc) wel_q <= 1'b1;
        CMD_WRDI: if (acc) wel_q <= 1'b0;
        CMD_WRSR: begin
          if (!busy_q) wel_q <= 1'b0;
          if (acc) begin
            nv_q      <= merge_nv(nv_q, wr_data_i, qpi_q);
            busy_q    <= 1'b1;
            busy_pe_q <= 1'b0;
          end
        end
        CMD_PROG, CMD_ERASE: if (acc) begin
          wel_q     <= 1'b0;
          busy_q    <= 1'b1;
          busy_pe_q <= 1'b1;
        end
        CMD_SUSPEND: if (acc) begin
          sus_q  <= 1'b1;
          busy_q <= 1'b0;
        end
        CMD_RESUME: if (acc) begin
          sus_q     <= 1'b0;
          busy_q    <= 1'b1;
          busy_pe_q <= 1'b1;
        end
        CMD_ENTER_QPI: if (acc) qpi_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign accept_o = acc;
  assign nv_o     = nv_q;
  assign wel_o    = wel_q;
  assign busy_o   = busy_q;
  assign sus_o    = sus_q;
  assign qpi_o    = qpi_q;

  // R9
  for (genvar i = 0; i < LB_W; i++) begin : g_lb_chk
    lb_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      nv_q.lb[i] |=> nv_q.lb[i]);
  end

  // R8
  otp_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_q.srp == PM_OTP) |=> (nv_q.srp == PM_OTP));

  // R8
  lockdown_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nv_q.srp == PM_LOCKDOWN && !pwr_cycle_i) |=> (nv_q.srp == PM_LOCKDOWN));

  // R4
  busy_nv_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !pwr_cycle_i) |=> $stable(nv_q));

  // R4
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !pwr_cycle_i && !op_done_i && cmd_i != CMD_SUSPEND) |=> busy_q);

  // R10
  sus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sus_q && !pwr_cycle_i && cmd_i != CMD_RESUME) |=> sus_q);

  // R11
  qpi_needs_qe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qpi_q |-> nv_q.qe);

  // R6
  wp_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_WRSR && !busy_q && !pwr_cycle_i && nv_q.srp == PM_PIN &&
     !nv_q.qe && !qpi_q && !wp_ni) |=> !busy_q);
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pwr_cycle_i,
  input  logic            wren_i,
  input  logic            wrdi_i,
  input  logic            wrsr_i,
  input  logic [SR_W-1:0] wr_data_i,
  input  logic            prog_i,
  input  logic            erase_i,
  input  logic            suspend_i,
  input  logic            resume_i,
  input  logic            enter_qpi_i,
  input  logic            wp_ni,
  input  logic            op_done_i,
  output logic [SR_W-1:0] status_o,
  output logic            qpi_mode_o,
  output logic            cmd_accept_o
);
  fsr_cmd_e cmd;
  fsr_nv_t  nv;
  logic     permit, wel, busy, sus, qpi;

  fsr_cmd_sel u_sel (
    .wren_i      (wren_i),
    .wrdi_i      (wrdi_i),
    .wrsr_i      (wrsr_i),
    .prog_i      (prog_i),
    .erase_i     (erase_i),
    .suspend_i   (suspend_i),
    .resume_i    (resume_i),
    .enter_qpi_i (enter_qpi_i),
    .cmd_o       (cmd)
  );

  fsr_access u_access (
    .srp_i    (nv.srp),
    .qe_i     (nv.qe),
    .qpi_i    (qpi),
    .wp_ni    (wp_ni),
    .permit_o (permit)
  );

  fsr_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pwr_cycle_i (pwr_cycle_i),
    .op_done_i   (op_done_i),
    .cmd_i       (cmd),
    .wr_data_i   (wr_data_i),
    .wr_permit_i (permit),
    .wp_ni       (wp_ni),
    .accept_o    (cmd_accept_o),
    .nv_o        (nv),
    .wel_o       (wel),
    .busy_o      (busy),
    .sus_o       (sus),
    .qpi_o       (qpi)
  );

  assign status_o   = pack_sr(nv, sus, wel, busy);
  assign qpi_mode_o = qpi;
endmodule

// File: tb/flash_status_ctrl_test.sv
module flash_status_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_cycle_i = 1'b0;
  logic        wren_i = 1'b0, wrdi_i = 1'b0, wrsr_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        prog_i = 1'b0, erase_i = 1'b0, suspend_i = 1'b0, resume_i = 1'b0;
  logic        enter_qpi_i = 1'b0, wp_ni = 1'b1, op_done_i = 1'b0;
  logic [15:0] status_o;
  logic        qpi_mode_o, cmd_accept_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  flash_status_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_cycle_i(pwr_cycle_i),
    .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i), .wr_data_i(wr_data_i),
    .prog_i(prog_i), .erase_i(erase_i), .suspend_i(suspend_i), .resume_i(resume_i),
    .enter_qpi_i(enter_qpi_i), .wp_ni(wp_ni), .op_done_i(op_done_i),
    .status_o(status_o), .qpi_mode_o(qpi_mode_o), .cmd_accept_o(cmd_accept_o)
  );

  // op: 1 wren 2 wrdi 3 wrsr 4 prog 5 erase 6 suspend 7 resume 8 qpi 9 done 10 pwr
  // {op, wp_n, exp_accept, data, exp_status}
  localparam int NV = 48;
  localparam logic [37:0] VEC [NV] = '{
    {4'd1, 1'b1,1'b1,16'h0000,16'h0002},  // R2
    {4'd2, 1'b1,1'b1,16'h0000,16'h0000},  // R2
    {4'd4, 1'b1,1'b0,16'h0000,16'h0000},  // R3 no WEL
    {4'd3, 1'b1,1'b0,16'h001C,16'h0000},  // R7 no WEL
    {4'd1, 1'b1,1'b1,16'h0000,16'h0002},
    {4'd3, 1'b1,1'b1,16'h803F,16'h003D},  // R5 R13
    {4'd1, 1'b1,1'b0,16'h0000,16'h003D},  // R4
    {4'd9, 1'b1,1'b0,16'h0000,16'h003C},  // R3 done
    {4'd1, 1'b1,1'b1,16'h0000,16'h003E},
    {4'd5, 1'b1,1'b1,16'h0000,16'h003D},  // R3
    {4'd6, 1'b1,1'b1,16'h0000,16'h803C},  // R10
    {4'd7, 1'b1,1'b1,16'h0000,16'h003D},  // R10
    {4'd9, 1'b1,1'b0,16'h0000,16'h003C},
    {4'd1, 1'b1,1'b1,16'h0000,16'h003E},
    {4'd3, 1'b1,1'b1,16'h0C80,16'h0881},  // R9 R13
    {4'd9, 1'b1,1'b0,16'h0000,16'h0880},
    {4'd1, 1'b1,1'b1,16'h0000,16'h0882},
    {4'd3, 1'b0,1'b0,16'h0000,16'h0880},  // R6 R7
    {4'd1, 1'b1,1'b1,16'h0000,16'h0882},
    {4'd3, 1'b1,1'b1,16'h0000,16'h0801},  // R6 R9
    {4'd9, 1'b1,1'b0,16'h0000,16'h0800},
    {4'd8, 1'b1,1'b0,16'h0000,16'h0800},  // R11
    {4'd1, 1'b1,1'b1,16'h0000,16'h0802},
    {4'd3, 1'b1,1'b1,16'h0200,16'h0A01},
    {4'd9, 1'b1,1'b0,16'h0000,16'h0A00},
    {4'd8, 1'b1,1'b1,16'h0000,16'h0A00},  // R11
    {4'd1, 1'b1,1'b1,16'h0000,16'h0A02},
    {4'd3, 1'b1,1'b1,16'h0000,16'h0A01},  // R11 QE kept
    {4'd9, 1'b1,1'b0,16'h0000,16'h0A00},
    {4'd10,1'b1,1'b0,16'h0000,16'h0A00},  // R12
    {4'd1, 1'b1,1'b1,16'h0000,16'h0A02},
    {4'd3, 1'b0,1'b1,16'h0280,16'h0A81},  // R5 pin ignored
    {4'd9, 1'b1,1'b0,16'h0000,16'h0A80},
    {4'd1, 1'b1,1'b1,16'h0000,16'h0A82},
    {4'd3, 1'b0,1'b1,16'h0300,16'h0B01},  // R6 QE=1
    {4'd9, 1'b1,1'b0,16'h0000,16'h0B00},
    {4'd1, 1'b1,1'b1,16'h0000,16'h0B02},
    {4'd3, 1'b1,1'b0,16'h0000,16'h0B00},  // R8 lockdown
    {4'd10,1'b1,1'b0,16'h0000,16'h0A00},  // R8 release
    {4'd6, 1'b1,1'b0,16'h0000,16'h0A00},  // R10 idle suspend
    {4'd1, 1'b1,1'b1,16'h0000,16'h0A02},
    {4'd3, 1'b1,1'b1,16'h0380,16'h0B81},
    {4'd9, 1'b1,1'b0,16'h0000,16'h0B80},
    {4'd1, 1'b1,1'b1,16'h0000,16'h0B82},
    {4'd3, 1'b1,1'b0,16'h0000,16'h0B80},  // R8 otp
    {4'd1, 1'b1,1'b1,16'h0000,16'h0B82},
    {4'd10,1'b1,1'b0,16'h0000,16'h0B80},  // R8 R12
    {4'd4, 1'b1,1'b0,16'h0000,16'h0B80}   // R12 WEL gone
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic wp, input logic [15:0] d);
    wp_ni       = wp;
    wr_data_i   = d;
    wren_i      = (op == 4'd1);
    wrdi_i      = (op == 4'd2);
    wrsr_i      = (op == 4'd3);
    prog_i      = (op == 4'd4);
    erase_i     = (op == 4'd5);
    suspend_i   = (op == 4'd6);
    resume_i    = (op == 4'd7);
    enter_qpi_i = (op == 4'd8);
    op_done_i   = (op == 4'd9);
    pwr_cycle_i = (op == 4'd10);
  endtask

  task automatic step(input logic [3:0] op, input logic wp, input logic [15:0] d,
                      input logic exp_acc, input logic [15:0] exp_sr, input string req);
    drive(op, wp, d);
    #1;
    check({req, " accept"}, {15'd0, cmd_accept_o}, {15'd0, exp_acc});
    @(negedge clk);
    check({req, " status"}, status_o, exp_sr);
    drive(4'd0, 1'b1, 16'h0000);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    check("R1 reset status", status_o, 16'h0000);
    check("R1 reset qpi", {15'd0, qpi_mode_o}, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][37:34], VEC[i][33], VEC[i][31:16], VEC[i][32], VEC[i][15:0],
           $sformatf("vec%0d", i));
      if (i == 25) check("R11 qpi entered", {15'd0, qpi_mode_o}, 16'h0001);
      if (i == 29) check("R12 qpi cleared", {15'd0, qpi_mode_o}, 16'h0000);
    end
    // R12 power cycle aborts busy program
    step(4'd1, 1'b1, 16'h0000, 1'b1, 16'h0B82, "R12 wren");
    step(4'd4, 1'b1, 16'h0000, 1'b1, 16'h0B81, "R3 prog");
    step(4'd6, 1'b1, 16'h0000, 1'b1, 16'h8B80, "R10 suspend");
    step(4'd10,1'b1, 16'h0000, 1'b0, 16'h0B80, "R12 pwr clears sus");
    // R1 hard reset returns factory state
    rst_ni = 1'b0;
    #1;
    check("R1 hard reset", status_o, 16'h0000);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule